// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Bit Slip

This block runs on the recovered bit-rate clock. It takes one serial data bit per clock and gathers the bits into 16-bit parallel words. Each finished word is presented together with a one-cycle word-valid strobe, so the strobe works as a word-rate clock enable for downstream logic. The first bit of a word lands in the most significant output bit.

Framing logic downstream searches for word alignment by raising the sync request. A request counts only after it has been held high for a minimum number of consecutive bit clocks (`MIN_HIGH`, default 4). When it counts, the bit sampled on that clock is discarded. The next word boundary therefore moves by one bit position, and a one-cycle slip-done pulse reports that the drop happened. A request that stays high yields a single slip. A further slip needs the request to fall and then be qualified again.

The sync qualifier is a three-state machine:
- `SQ_IDLE`: the request is low. On a high sample it goes to `SQ_COUNT`, with the run count set to one.
- `SQ_COUNT`: it counts consecutive high samples. A low sample returns it to `SQ_IDLE`, which is the "too short" transition. The `MIN_HIGH`-th high sample drops a bit and moves it to `SQ_HOLD`, which is the "accept" transition.
- `SQ_HOLD`: it waits until the request falls, then goes to `SQ_IDLE`, which is the "re-arm" transition.

Top module: `bitslip_deser`

## Requirements
- R1: The bit sampled first in a word appears on `word_out[15]` and the bit sampled last appears on `word_out[0]`.
- R2: After reset release, `word_vld` is high for exactly one cycle following the 16th accepted bit. The first bit is sampled on the first rising edge after release, and each later strobe follows every further 16 accepted bits.
- R3: `word_out` changes only in a cycle where `word_vld` is high. At all other times it holds its value.
- R4: A sync request is accepted on the rising edge at which `sync_in` has been sampled high for the 4th consecutive time (`MIN_HIGH`). The serial bit sampled on that edge is discarded.
- R5: A sync pulse sampled high on fewer than 4 consecutive edges causes no slip. The word strobe timing and the data stay unchanged.
- R6: A sync request that stays high causes exactly one slip. Another slip needs at least one low sample followed by a new qualifying run.
- R7: `slip_done` is high for exactly the one cycle after the edge that discarded a bit. The word that contains the slip is strobed one bit period later than it would have been without the slip.
- R8: While `rst_n` is low, `word_out` is all zeros, and `word_vld` and `slip_done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data bit |
| sync_in | input | 1 | Word realignment request, level sensitive |
| word_out | output | 16 | Assembled parallel word; first received bit in bit 15 |
| word_vld | output | 1 | One-cycle strobe marking a new word on `word_out` |
| slip_done | output | 1 | One-cycle pulse after a serial bit was discarded |

## Verification
A bit counter holding a wrong value shows up at the next word strobe, which then arrives early or late, so an error is visible within 17 bit clocks. A wrong run count or qualifier state shows up in the cycle after the disputed edge: `slip_done` appears where no slip is due, or is missing where one is due. Within the same word the data is also off by one position. Each cycle, the bench compares all three outputs against a queue-based model that tracks the accepted bits and the sync history, so any of these faults is caught as soon as it reaches a port.

// File: rtl/bitslip_deser_pkg.sv
package bitslip_deser_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_COUNT = 2'd1,
        SQ_HOLD  = 2'd2
    } sq_state_e;

endpackage

// File: rtl/slip_qualifier.sv
module slip_qualifier
    import bitslip_deser_pkg::*;
#(
    parameter int MIN_HIGH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic slip_now
);
    localparam int HC_W = (MIN_HIGH > 2) ? $clog2(MIN_HIGH) : 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(MIN_HIGH - 1);
    localparam logic [HC_W-1:0] HC_ONE  = HC_W'(1);

    sq_state_e       state_q, state_d;
    logic [HC_W-1:0] hc_q, hc_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            hc_q    <= '0;
        end else begin
            state_q <= state_d;
            hc_q    <= hc_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        hc_d    = hc_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (sync_in) begin
                    state_d = SQ_COUNT;
                    hc_d    = HC_ONE;
                end
            end
            SQ_COUNT: begin
                if (!sync_in) begin
                    state_d = SQ_IDLE;
                    hc_d    = '0;
                end else if (hc_q == HC_LAST) begin
                    state_d = SQ_HOLD;
                    hc_d    = '0;
                end else begin
                    hc_d = hc_q + HC_ONE;
                end
            end
            SQ_HOLD: begin
                if (!sync_in) begin
                    state_d = SQ_IDLE;
                end
            end
            default: begin
                state_d = SQ_IDLE;
                hc_d    = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        slip_now = (state_q == SQ_COUNT) && sync_in && (hc_q == HC_LAST);
    end

endmodule

// File: rtl/word_assembler.sv
module word_assembler #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             drop,
    output logic [WIDTH-1:0] word_q,
    output logic             word_vld_q
);
    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIDTH - 1);

    logic [CNT_W-1:0] bit_cnt_q;
    logic [WIDTH-2:0] shift_q;
    logic             take;
    logic             last_bit;

    always_comb begin
        take     = !drop;
        last_bit = take && (bit_cnt_q == CNT_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            shift_q    <= '0;
            word_q     <= '0;
            word_vld_q <= 1'b0;
        end else begin
            word_vld_q <= last_bit;
            if (take) begin
                shift_q   <= {shift_q[WIDTH-3:0], bit_in};
                bit_cnt_q <= last_bit ? '0 : bit_cnt_q + CNT_W'(1);
            end
            if (last_bit) begin
                word_q <= {shift_q, bit_in};
            end
        end
    end

endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser #(
    parameter int WIDTH    = 16,
    parameter int MIN_HIGH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             sync_in,
    output logic [WIDTH-1:0] word_out,
    output logic             word_vld,
    output logic             slip_done
);
    logic slip_now;

    slip_qualifier #(.MIN_HIGH(MIN_HIGH)) qual_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_in),
        .slip_now (slip_now)
    );

    word_assembler #(.WIDTH(WIDTH)) asm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_in     (ser_in),
        .drop       (slip_now),
        .word_q     (word_out),
        .word_vld_q (word_vld)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slip_done <= 1'b0;
        end else begin
            slip_done <= slip_now;
        end
    end

endmodule

// File: rtl/bitslip_deser_chk.sv
module bitslip_deser_chk #(
    parameter int WIDTH    = 16,
    parameter int MIN_HIGH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_in,
    input logic [WIDTH-1:0] word_out,
    input logic             word_vld,
    input logic             slip_done
);
    localparam int RUN_W = $clog2(MIN_HIGH + 2);
    localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

    logic [RUN_W-1:0] run_q;
    logic             used_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            used_q <= 1'b0;
        end else begin
            if (!sync_in) run_q <= '0;
            else if (run_q != RUN_MAX) run_q <= run_q + RUN_W'(1);
            if (!sync_in) used_q <= 1'b0;
            else if (slip_done) used_q <= 1'b1;
        end
    end

    // R2
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);

    // R3
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |-> $stable(word_out));

    // R4
    slip_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slip_done |-> (int'(run_q) >= MIN_HIGH));

    // R6
    one_slip_per_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slip_done |-> !used_q);

    // R7
    slip_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slip_done |=> !slip_done);

endmodule

bind bitslip_deser bitslip_deser_chk #(.WIDTH(WIDTH), .MIN_HIGH(MIN_HIGH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_in),
    .word_out  (word_out),
    .word_vld  (word_vld),
    .slip_done (slip_done)
);

// File: tb/bitslip_deser_tb_top.sv
`timescale 1ns/1ps
module bitslip_deser_tb_top;
    localparam int W    = 16;
    localparam int MINH = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_in = 1'b0;
    logic         sync_in = 1'b0;
    logic [W-1:0] word_out;
    logic         word_vld;
    logic         slip_done;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bitslip_deser #(.WIDTH(W), .MIN_HIGH(MINH)) dut_i (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .sync_in(sync_in),
        .word_out(word_out), .word_vld(word_vld), .slip_done(slip_done)
    );

    // behavioural reference model
    bit           q[$];
    int           run;
    bit           used;
    logic [W-1:0] m_word;
    bit           m_vld;
    bit           m_slip;
    int           n_slips;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            run = 0; used = 0; m_word = '0; m_vld = 0; m_slip = 0;
        end else begin
            bit slip;
            if (sync_in) run++;
            else begin run = 0; used = 0; end
            slip = sync_in && (run == MINH) && !used;   // R4, R5, R6
            if (slip) begin used = 1; n_slips++; end
            m_slip = slip;
            m_vld  = 0;
            if (!slip) begin
                q.push_back(ser_in);
                if (q.size() == W) begin
                    for (int i = 0; i < W; i++) m_word[W-1-i] = q[i];   // R1
                    m_vld = 1;
                    q.delete();
                end
            end
        end
    end

    // comparison on every clock
    always @(negedge clk) begin
        if (!done) begin
            string tv, tw, ts;
            tv = !rst_n ? "R8" : "R2/R7";
            tw = !rst_n ? "R8" : (m_vld ? "R1" : "R3");
            ts = !rst_n ? "R8" : "R4/R5/R6";
            checks++;
            if (word_vld !== m_vld) begin
                errors++;
                $display("FAIL %s word_vld actual=%0b expected=%0b t=%0t", tv, word_vld, m_vld, $time);
            end
            checks++;
            if (word_out !== m_word) begin
                errors++;
                $display("FAIL %s word_out actual=%04h expected=%04h t=%0t", tw, word_out, m_word, $time);
            end
            checks++;
            if (slip_done !== m_slip) begin
                errors++;
                $display("FAIL %s slip_done actual=%0b expected=%0b t=%0t", ts, slip_done, m_slip, $time);
            end
        end
    end

    task automatic drive(input int n, input bit s);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ser_in  = 1'($urandom);
            sync_in = s;
        end
    endtask

    task automatic drive_const(input int n, input bit b);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ser_in  = b;
            sync_in = 1'b0;
        end
    endtask

    initial begin
        n_slips = 0;
        // R8: reset state held for several cycles
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R2: first strobe 16 clocks after the first bit; R1 bit order with a marker
        @(negedge clk); ser_in = 1'b1; sync_in = 1'b0;
        drive_const(15, 1'b0);
        drive(64, 1'b0);
        // R5: short pulses of 1, 2 and 3 cycles are ignored
        for (int w = 1; w < MINH; w++) begin
            drive(w, 1'b1);
            drive(5, 1'b0);
        end
        drive(40, 1'b0);
        // R4, R7: minimum-width pulse causes one slip
        drive(MINH, 1'b1);
        drive(40, 1'b0);
        // R6: sustained pulse slips once only
        drive(30, 1'b1);
        drive(20, 1'b0);
        // R6: single low sample re-arms
        drive(MINH, 1'b1);
        drive(1, 1'b0);
        drive(MINH, 1'b1);
        drive(40, 1'b0);
        // mixed random sync runs
        for (int r = 0; r < 200; r++) begin
            drive($urandom_range(1, 8), 1'b1);
            drive($urandom_range(1, 20), 1'b0);
        end
        // R8: reset asserted mid-word clears outputs
        drive(7, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        drive(3, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        drive(50, 1'b0);
        // model sanity: slips must have occurred (R4)
        checks++;
        if (n_slips < 4) begin
            errors++;
            $display("FAIL R4 slip count actual=%0d expected>=4", n_slips);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule